// File: doc/BRIEF.md
# Dual-Width Register Bank

This block is a slave register bank of 512 internal 32-bit registers that a host reaches through a 1024-location word address window. Bus address bits [9:1] select the register. Bit 0 selects a half only while the bank is in its narrow access mode. After reset the bank is in that narrow mode. Each register then appears as two 16-bit halves at a pair of consecutive addresses.

Setting one bit in a control register switches the bank to a wide mode. In wide mode every access moves a whole 32-bit register. A command register starts a busy countdown, and the host polls a read-only status register until the busy flag drops. Reads are registered, so data and a valid strobe appear one cycle after the read strobe.

Top module: `dual_width_regbank`

## Requirements
- R1: After reset every register reads zero, the bank is in narrow mode, busy is clear and `rvalid` is low.
- R2: Register N is addressed at bus addresses 2N and 2N+1; bits [9:1] of `addr` form the register index.
- R3: In narrow mode, a write to an even address stores `wdata[15:0]` into bits 15:0 of the register, and a write to an odd address stores `wdata[15:0]` into bits 31:16. The other half of the register keeps its value.
- R4: In narrow mode, a read returns the addressed half zero-extended to 32 bits: bits 15:0 for an even address, bits 31:16 for an odd address.
- R5: In wide mode, a read or write at either the even or the odd address of a register transfers all 32 bits of that register.
- R6: The mode is bit 0 of the control register (register 64, addresses 128/129), where 1 selects wide mode. A change takes effect for the access in the next cycle after the write. The bit can be written in either mode. A narrow write to address 129 does not change the mode.
- R7: Any write to the command register (register 44, addresses 88/89) sets busy, and busy clears BUSY_CYCLES cycles later. Busy is reported on bit 4 of the status register (register 123, addresses 246/247), which also reports the mode on bit 0 and zero on all other bits.
- R8: Writes to the status register have no effect: later reads of it still show only the busy and mode bits.
- R9: `rdata` and `rvalid` are registered. `rvalid` is high exactly in the cycle after `rd_en`, and `rdata` holds its value when there is no read. A read issued in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 10 | Word address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when rvalid is high |
| rvalid | output | 1 | High one cycle after rd_en |

## Verification
Two situations are hard to reach from the ports.

The first is the mode change landing exactly one cycle after the control write. The stimulus writes the mode bit and, on the very next edge, issues an odd-address write that must store a full word. It then switches back with a wide write and reads the same register as halves.

The second is the edge of the busy window. The stimulus reads status on the first cycle after the command write and again just after the countdown ends. A same-cycle read and write to one register shows whether read data comes from before or after the update.

// File: rtl/dual_width_regbank.sv
module dual_width_regbank #(
  parameter int ADDR_W      = 10,
  parameter int BUSY_CYCLES = 8,
  parameter int CTRL_IDX    = 64,
  parameter int MODE_BIT    = 0,
  parameter int CMD_IDX     = 44,
  parameter int STAT_IDX    = 123,
  parameter int BUSY_BIT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int NREG  = 1 << IDX_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [IDX_W-1:0] CTRL_I = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] CMD_I  = IDX_W'(CMD_IDX);
  localparam logic [IDX_W-1:0] STAT_I = IDX_W'(STAT_IDX);

  logic [31:0]      regs [NREG];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             wide, busy, cmd_wr, hi_half;
  logic [31:0]      stat_word, word;

  assign idx     = addr[ADDR_W-1:1];
  assign hi_half = addr[0];
  assign wide    = regs[CTRL_I][MODE_BIT];
  assign busy    = cnt != '0;
  assign cmd_wr  = wr_en && idx == CMD_I;

  always_comb begin
    stat_word = '0;
    stat_word[BUSY_BIT] = busy;
    stat_word[0] = wide;
  end

  assign word = (idx == STAT_I) ? stat_word : regs[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && idx != STAT_I) begin
      if (wide)         regs[idx]        <= wdata;
      else if (hi_half) regs[idx][31:16] <= wdata[15:0];
      else              regs[idx][15:0]  <= wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (cmd_wr)  cnt <= CNT_W'(BUSY_CYCLES);
    else if (busy)    cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)
        rdata <= wide ? word : {16'h0, hi_half ? word[31:16] : word[15:0]};
    end
  end

  p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_rvalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rvalid && $stable(rdata)));
  p_narrow_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wide) |=> rdata[31:16] == 16'h0);
  p_cmd_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> busy);
  p_busy_decays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_wr) |=> cnt == $past(cnt) - 1'b1);
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == CTRL_I) |=> $stable(wide));
endmodule

// File: tb/tb_dual_width_regbank.sv
module tb_dual_width_regbank;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  int n_chk = 0, n_bad = 0, cyc = 0;

  dual_width_regbank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  always #5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk("R9 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rvalid low", {31'b0, rvalid}, 0);
    rd(10'd40, d); chk("R1 reg zero", d, 0);
    rd(10'd246, d); chk("R1 status idle", d, 0);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    wr(10'd10, 32'hFFFF_1234);
    wr(10'd11, 32'h0000_ABCD);
    rd(10'd10, d); chk("R3 low half", d, 32'h0000_1234);
    rd(10'd11, d); chk("R4 high half zext", d, 32'h0000_ABCD);
    wr(10'd10, 32'h0000_5555);
    rd(10'd11, d); chk("R3 other half kept", d, 32'h0000_ABCD);
    rd(10'd12, d); chk("R2 neighbour untouched", d, 0);
    @(negedge clk); chk("R9 rvalid drops", {31'b0, rvalid}, 0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(10'd129, 32'h0000_0001);
    rd(10'd246, d); chk("R6 upper write no mode", d, 0);
    @(negedge clk); wr_en = 1; addr = 10'd128; wdata = 32'h1;
    @(negedge clk); addr = 10'd21; wdata = 32'hA5A5_0F0F;
    @(negedge clk); wr_en = 0;
    rd(10'd20, d); chk("R5 odd write full", d, 32'hA5A5_0F0F);
    rd(10'd21, d); chk("R5 odd read full", d, 32'hA5A5_0F0F);
    rd(10'd246, d); chk("R6 status wide", d, 32'h1);
    rd(10'd128, d); chk("R6 ctrl full word", d, 32'h0001_0001);
    wr(10'd128, 32'h0);
    rd(10'd21, d); chk("R6 back to narrow", d, 32'h0000_A5A5);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(10'd89, 32'h7);
    rd(10'd246, d); chk("R7 busy set", d, 32'h10);
    repeat (10) @(negedge clk);
    rd(10'd246, d); chk("R7 busy cleared", d, 0);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(10'd246, 32'hFFFF);
    wr(10'd247, 32'hFFFF);
    rd(10'd246, d); chk("R8 status low unchanged", d, 0);
    rd(10'd247, d); chk("R8 status high unchanged", d, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(10'd30, 32'h0000_1111);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 10'd30; wdata = 32'h2222;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R9 old value on collision", rdata, 32'h1111);
    rd(10'd30, d); chk("R9 new value after", d, 32'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_mode();
    t_busy();
    t_status_ro();
    t_same_cycle();
    summary();
  end
endmodule